// File: doc/BRIEF.md
# Unbuffered Synchronous Serial Shifter

This block is an 8-bit clocked serial port with a single shift register. That register holds the byte to send, and it also collects the byte that arrives. There is no separate transmit or receive buffer. A CPU-side register file sets the mode, the divisor and the data. Writing the data register starts a transfer. Each clock pulse shifts one bit out on the serial output and one bit in from the serial input. After eight pulses the register holds the received byte, ready to be read back.

The transfer clock comes from one of two places. It can be made internally from the system clock, through a prescaler (divide by 1, 8 or 32) and an 8-bit divider. It can also be taken from an external pin, which passes through a two-flop synchroniser and an edge detector.

The polarity, the bit order and the output idle level can all be chosen. A one-cycle interrupt pulse marks the last sampling edge. With the internal clock, the output keeps its last bit for half a clock period after the transfer and then floats.

The control is a four-state machine:
- ST_IDLE: no transfer.
- ST_SHIFT: internal clock running.
- ST_HOLD: internal half-period hold of the output after the last edge.
- ST_EXT: external clock transfer.

Transitions:
- ST_IDLE to ST_SHIFT or ST_EXT: on an accepted data write, depending on the clock source.
- ST_SHIFT to ST_HOLD: on the sixteenth internal edge.
- ST_HOLD to ST_IDLE: on the next half-period tick.
- ST_HOLD to ST_SHIFT: on a data write.
- ST_EXT to ST_IDLE: on the eighth external sampling edge.
- Any state to ST_IDLE: when the clock-source bit no longer matches the state.

Top module: `sync_shift_unit`

## Requirements
- R1: Register addresses are 0 for control, 1 for divisor, 2 for data and 3 for status. Control fields: bit0 = internal clock, bit1 = polarity, bit2 = MSB first, bit3 = external-mode idle level, bits5:4 = prescaler select. Status fields: bit0 = busy, bit1 = overrun. All registers reset to zero, which selects external clock mode with an idle output of 0.
- R2: With the internal clock, every transfer-clock half period lasts (n+1)*P system cycles. Here n is the divisor and P is 1, 8 or 32 for a prescaler select of 0, 1, or 2 and 3.
- R3: With the internal clock, sclk_oe is 1 and exactly 8 pulses (16 edges) are produced. The clock then rests high when polarity is 0 and low when polarity is 1.
- R4: With polarity 0, data changes on falling edges and sdi is sampled on rising edges; polarity 1 swaps the two edges. Bits go out bit 7 first when MSB first is set, otherwise bit 0 first.
- R5: After a transfer, the data register holds the 8 sampled sdi bits. The first sampled bit is placed at bit 7 in MSB-first order and at bit 0 in LSB-first order.
- R6: irq is a single-cycle pulse in the cycle after the eighth sampling edge, and busy is low while it is high.
- R7: With the internal clock, sdo_oe is 0 from the data write until the first clock edge. After the last edge, sdo keeps driving the last bit for one half period (n+1)*P and then sdo_oe falls to 0.
- R8: A data write during the hold period clears sdo_oe in the next cycle and starts a new transfer.
- R9: A data write while busy is ignored and the transfer continues on its original timing; the write sets the sticky overrun flag. Any write to the status address clears the flag.
- R10: With the external clock, sdo_oe is always 1 and sclk_oe is 0. While no transfer is active, sdo shows the idle-level bit.
- R11: With the external clock, sampling edges on sclk_in shift the register. irq fires on the eighth sampling edge after a data write. Further edges after that keep shifting the register without raising irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| irq | output | 1 | Transfer-complete pulse |

## Verification
The hardest condition to reach is a data write that lands inside the short hold window after an internal transfer. The window exists only for (n+1)*P cycles, and it starts on the same edge as the completion pulse. The bench chooses a divisor that makes the window several cycles long. It watches for irq at each falling clock edge and issues the write on the next cycle. It then checks that the drive enable has dropped and that a fresh transfer is busy. The ignored write during a transfer is found by timing: the interrupt must arrive exactly 16 half periods after the first write and not after the second.

// File: rtl/sss_pkg.sv
package sss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_EXT
    } sss_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_W    = 6;
    localparam int CB_INT    = 0;
    localparam int CB_POL    = 1;
    localparam int CB_MSB    = 2;
    localparam int CB_IDLE   = 3;
    localparam int CB_PSC_LO = 4;

endpackage

// File: rtl/sss_baud_gen.sv
module sss_baud_gen #(
    parameter int DIV_W   = 8,
    parameter int PSC_MID = 8,
    parameter int PSC_HI  = 32,
    localparam int PSC_W  = $clog2(PSC_HI)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [1:0]       psc_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             half_tick
);

    logic [PSC_W-1:0] psc_cnt_q;
    logic [PSC_W-1:0] psc_last;
    logic [DIV_W-1:0] div_cnt_q;
    logic             pre_tick;

    always_comb begin
        case (psc_sel)
            2'd0:    psc_last = '0;
            2'd1:    psc_last = PSC_W'(PSC_MID - 1);
            default: psc_last = PSC_W'(PSC_HI - 1);
        endcase
    end

    assign pre_tick  = (psc_cnt_q == psc_last);
    assign half_tick = run && pre_tick && (div_cnt_q == divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_cnt_q <= '0;
            div_cnt_q <= '0;
        end else if (!run || clr) begin
            psc_cnt_q <= '0;
            div_cnt_q <= '0;
        end else if (pre_tick) begin
            psc_cnt_q <= '0;
            div_cnt_q <= (div_cnt_q == divisor) ? '0 : div_cnt_q + 1'b1;
        end else begin
            psc_cnt_q <= psc_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sss_edge_sync.sv
module sss_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/sync_shift_unit.sv
module sync_shift_unit
    import sss_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq
);

    sss_state_e        state_q, state_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  edge_cnt_q;
    logic              sdo_q;
    logic              sclk_q;
    logic              ovr_q;
    logic              irq_q;

    logic c_int, c_pol, c_msb, c_idle;
    logic [1:0] c_psc;
    assign c_int  = ctrl_q[CB_INT];
    assign c_pol  = ctrl_q[CB_POL];
    assign c_msb  = ctrl_q[CB_MSB];
    assign c_idle = ctrl_q[CB_IDLE];
    assign c_psc  = ctrl_q[CB_PSC_LO +: 2];

    logic data_wr, active, start, ovr_set;
    logic half_tick, run, ext_rise, ext_fall;
    logic int_edge, launch_int, sample_int, last_int;
    logic launch_ext, sample_ext, last_ext;
    logic do_sample, do_launch;

    assign data_wr = wr_en && (wr_addr == ADDR_DATA);
    assign active  = (state_q == ST_SHIFT) || (state_q == ST_EXT);
    assign start   = data_wr && !active;
    assign ovr_set = data_wr && active;
    assign run     = (state_q == ST_SHIFT) || (state_q == ST_HOLD);

    sss_baud_gen #(.DIV_W(DIV_W)) i_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clr       (start),
        .psc_sel   (c_psc),
        .divisor   (div_q),
        .half_tick (half_tick)
    );

    sss_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sclk_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Internal clock: even-numbered edges launch, odd-numbered edges sample.
    assign int_edge   = (state_q == ST_SHIFT) && half_tick;
    assign launch_int = int_edge && !edge_cnt_q[0];
    assign sample_int = int_edge &&  edge_cnt_q[0];
    assign last_int   = sample_int && (edge_cnt_q == CNT_W'(2 * DATA_W - 1));

    // External clock: edge roles set by polarity; sampling shifts in any state.
    assign launch_ext = !c_int && (c_pol ? ext_rise : ext_fall);
    assign sample_ext = !c_int && (c_pol ? ext_fall : ext_rise);
    assign last_ext   = (state_q == ST_EXT) && sample_ext &&
                        (edge_cnt_q == CNT_W'(DATA_W - 1));

    assign do_sample = sample_int || sample_ext;
    assign do_launch = launch_int || (launch_ext && (state_q == ST_EXT));

    function automatic logic first_bit(input logic [DATA_W-1:0] v, input logic msb);
        return msb ? v[DATA_W-1] : v[0];
    endfunction

    function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                   input logic msb, input logic b);
        return msb ? {v[DATA_W-2:0], b} : {b, v[DATA_W-1:1]};
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = c_int ? ST_SHIFT : ST_EXT;
            end
            ST_SHIFT: begin
                if (!c_int)        state_d = ST_IDLE;
                else if (last_int) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!c_int)         state_d = ST_IDLE;
                else if (start)     state_d = ST_SHIFT;
                else if (half_tick) state_d = ST_IDLE;
            end
            ST_EXT: begin
                if (c_int)         state_d = ST_IDLE;
                else if (last_ext) state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            div_q      <= '0;
            shreg_q    <= '0;
            edge_cnt_q <= '0;
            sdo_q      <= 1'b0;
            sclk_q     <= 1'b1;
            ovr_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= last_int || last_ext;

            if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_en && wr_addr == ADDR_DIV)  div_q  <= wr_data[DIV_W-1:0];

            if (wr_en && wr_addr == ADDR_STAT) ovr_q <= 1'b0;
            else if (ovr_set)                  ovr_q <= 1'b1;

            if (start) begin
                shreg_q    <= wr_data;
                sdo_q      <= first_bit(wr_data, c_msb);
                edge_cnt_q <= '0;
            end else begin
                if (do_sample) shreg_q <= shift_in(shreg_q, c_msb, sdi);
                if (do_launch) sdo_q   <= first_bit(shreg_q, c_msb);
                if (int_edge)
                    edge_cnt_q <= last_int ? '0 : edge_cnt_q + 1'b1;
                else if ((state_q == ST_EXT) && sample_ext)
                    edge_cnt_q <= last_ext ? '0 : edge_cnt_q + 1'b1;
            end

            if (int_edge)                 sclk_q <= ~sclk_q;
            else if (state_q != ST_SHIFT) sclk_q <= ~c_pol;
        end
    end

    // Outputs
    always_comb begin
        sclk_out = sclk_q;
        sclk_oe  = c_int;
        irq      = irq_q;
        if (c_int) begin
            sdo    = sdo_q;
            sdo_oe = ((state_q == ST_SHIFT) && (edge_cnt_q != '0)) ||
                     (state_q == ST_HOLD);
        end else begin
            sdo    = (state_q == ST_EXT) ? sdo_q : c_idle;
            sdo_oe = 1'b1;
        end
        unique case (rd_addr)
            ADDR_CTRL: rd_data = DATA_W'(ctrl_q);
            ADDR_DIV:  rd_data = DATA_W'(div_q);
            ADDR_DATA: rd_data = shreg_q;
            ADDR_STAT: rd_data = DATA_W'({ovr_q, active});
        endcase
    end

endmodule

// File: rtl/sync_shift_unit_chk.sv
module sync_shift_unit_chk
    import sss_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       sdo_oe,
    input logic       sclk_out,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input sss_state_e state,
    input logic       ovr,
    input logic       c_int,
    input logic       c_pol
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state != ST_SHIFT && state != ST_EXT)); // R6

    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_int && state != ST_SHIFT && $stable(c_pol) && $stable(c_int))
        |-> (sclk_out == !c_pol)); // R3

    AST_EXT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !c_int |-> sdo_oe); // R10

    AST_INT_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_int && state == ST_IDLE) |-> !sdo_oe); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(wr_en && wr_addr == ADDR_STAT)) |=> ovr); // R9

    AST_OVR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA && (state == ST_SHIFT || state == ST_EXT))
        |=> ovr); // R9

endmodule

bind sync_shift_unit sync_shift_unit_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .sdo_oe   (sdo_oe),
    .sclk_out (sclk_out),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .state    (state_q),
    .ovr      (ovr_q),
    .c_int    (ctrl_q[0]),
    .c_pol    (ctrl_q[1])
);

// File: tb/test_sync_shift_unit.sv
module test_sync_shift_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sclk_in = 1'b0;
    logic       sclk_out, sclk_oe;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int irq_cyc = 0;
    bit finished = 0;

    sync_shift_unit i_sync_shift_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (irq) begin
            irq_cnt++;
            irq_cyc = cyc;
        end
    end

    // ctrl, divisor, transmit byte, byte presented on sdi
    localparam logic [31:0] VEC [0:3] = '{
        32'h01_00_A5_3C,   // internal, pol0, LSB first, P=1
        32'h07_02_81_7E,   // internal, pol1, MSB first, P=1
        32'h15_01_5A_C3,   // internal, pol0, MSB first, P=8
        32'h23_00_F0_0F    // internal, pol1, LSB first, P=32
    };

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic logic pick(input logic [7:0] v, input logic msb, input int k);
        return msb ? v[7 - k] : v[k];
    endfunction

    task automatic wait_irq(input int limit);
        int base;
        base = irq_cnt;
        for (int g = 0; g < limit && irq_cnt == base; g++) tick();
    endtask

    task automatic run_int(input logic [7:0] ctrl, input logic [7:0] dv,
                           input logic [7:0] tx, input logic [7:0] rx);
        int  h, edges, k, t2, hc, v, irq0;
        logic pol, msb, prev;
        logic [7:0] got, exp_seq;
        bit done;
        pol = ctrl[1];
        msb = ctrl[2];
        h = (int'(dv) + 1) * ((ctrl[5:4] == 2'd0) ? 1 : (ctrl[5:4] == 2'd1) ? 8 : 32);
        reg_wr(2'd0, ctrl);
        reg_wr(2'd1, dv);
        tick(); tick();
        chk("R3", "sclk_oe internal", int'(sclk_oe), 1);
        chk("R3", "rest level before", int'(sclk_out), int'(!pol));
        sdi = pick(rx, msb, 0);
        irq0 = irq_cnt;
        reg_wr(2'd2, tx);
        chk("R7", "sdo_oe before first edge", int'(sdo_oe), 0);
        prev = sclk_out;
        edges = 0; k = 0; t2 = 0; got = '0; done = 0;
        for (int g = 0; g < 20000 && !done; g++) begin
            tick();
            if (sclk_out != prev) begin
                edges++;
                if (edges == 2) t2 = cyc;
                if (edges == 3) chk("R2", "half period", cyc - t2, h);
                if (sclk_out == !pol && k < 8) begin
                    got[k] = sdo;
                    k++;
                    if (k < 8) sdi = pick(rx, msb, k);
                end
            end
            prev = sclk_out;
            if (irq) done = 1;
        end
        chk("R6", "irq seen", int'(done), 1);
        chk("R7", "sdo holds last bit", int'(sdo), int'(pick(tx, msb, 7)));
        hc = 0;
        for (int g = 0; g < 20000 && sdo_oe; g++) begin
            hc++;
            tick();
            if (sclk_out != prev) edges++;
            prev = sclk_out;
        end
        chk("R7", "hold length", hc, h);
        chk("R3", "edge count", edges, 16);
        chk("R3", "rest level after", int'(sclk_out), int'(!pol));
        for (int i = 0; i < 8; i++) exp_seq[i] = pick(tx, msb, i);
        chk("R4", "transmit sequence", int'(got), int'(exp_seq));
        reg_rd(2'd2, v);
        chk("R5", "received byte", v, int'(rx));
        chk("R6", "one irq per transfer", irq_cnt - irq0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v, t0, irq0;
        logic [7:0] got, exp_seq;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // Reset state
        reg_rd(2'd0, v); chk("R1", "ctrl reset", v, 0);
        reg_rd(2'd1, v); chk("R1", "divisor reset", v, 0);
        reg_rd(2'd2, v); chk("R1", "data reset", v, 0);
        reg_rd(2'd3, v); chk("R1", "status reset", v, 0);
        chk("R1", "irq reset", int'(irq), 0);
        chk("R10", "sdo_oe reset", int'(sdo_oe), 1);
        chk("R10", "sdo idle reset", int'(sdo), 0);
        chk("R10", "sclk_oe reset", int'(sclk_oe), 0);

        // Vector table
        for (int i = 0; i < 4; i++) begin
            run_int(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            tick();
        end

        // R9: write while busy is ignored, sets overrun; status write clears
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd1, 8'd3);
        sdi = 1'b0;
        reg_wr(2'd2, 8'h11);
        t0 = cyc;
        tick(); tick(); tick();
        reg_rd(2'd3, v); chk("R9", "busy during transfer", v & 1, 1);
        reg_wr(2'd2, 8'hEE);
        reg_rd(2'd3, v); chk("R9", "overrun set", (v >> 1) & 1, 1);
        wait_irq(2000);
        chk("R9", "transfer not restarted", irq_cyc - t0, 64);
        reg_rd(2'd2, v); chk("R9", "received after overrun", v, 0);
        reg_rd(2'd3, v); chk("R9", "overrun sticky", (v >> 1) & 1, 1);
        reg_wr(2'd3, 8'h00);
        reg_rd(2'd3, v); chk("R9", "overrun cleared", (v >> 1) & 1, 0);
        repeat (8) tick();

        // R8: write inside the hold window
        reg_wr(2'd2, 8'hFF);
        wait_irq(2000);
        chk("R8", "in hold drives", int'(sdo_oe), 1);
        irq0 = irq_cnt;
        reg_wr(2'd2, 8'h00);
        chk("R8", "hold cut short", int'(sdo_oe), 0);
        reg_rd(2'd3, v); chk("R8", "new transfer busy, no overrun", v, 1);
        wait_irq(2000);
        chk("R8", "second transfer completes", irq_cnt - irq0, 1);
        repeat (8) tick();

        // R10/R11: external clock, pol0, MSB first, idle level 1
        reg_wr(2'd0, 8'h0C);
        tick();
        chk("R10", "idle level driven", int'(sdo), 1);
        chk("R10", "sdo_oe external", int'(sdo_oe), 1);
        chk("R10", "sclk_oe external", int'(sclk_oe), 0);
        sclk_in = 1'b1;
        repeat (6) tick();
        irq0 = irq_cnt;
        sdi = pick(8'hB4, 1'b1, 0);
        reg_wr(2'd2, 8'h69);
        chk("R11", "first bit after write", int'(sdo), 0);
        got = '0;
        for (int k = 0; k < 8; k++) begin
            sclk_in = 1'b0;
            repeat (6) tick();
            got[k] = sdo;
            sdi = pick(8'hB4, 1'b1, k);
            sclk_in = 1'b1;
            repeat (6) tick();
        end
        for (int i = 0; i < 8; i++) exp_seq[i] = pick(8'h69, 1'b1, i);
        chk("R11", "external transmit sequence", int'(got), int'(exp_seq));
        chk("R11", "external irq count", irq_cnt - irq0, 1);
        reg_rd(2'd2, v); chk("R11", "external received byte", v, 8'hB4);
        chk("R10", "idle level after transfer", int'(sdo), 1);
        sdi = 1'b1;
        sclk_in = 1'b0; repeat (6) tick();
        sclk_in = 1'b1; repeat (6) tick();
        reg_rd(2'd2, v); chk("R11", "extra edge shifts", v, 8'h69);
        chk("R11", "extra edge no irq", irq_cnt - irq0, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule